// File: doc/BRIEF.md
# Serial Bit Scrambler with Ones-Run Guard

This block sits in a transmit path between a character serialiser and a modulator. Each time the bit-clock enable is high, it takes one data bit and produces one line bit. When scrambling is on, the line bit is the input bit XORed with the line bits sent 14 and 17 bit times earlier. This is the self-synchronising form of the polynomial 1 + x^-14 + x^-17. A matching descrambler on the far side recovers the data from the line bits alone.

A scrambler of this kind can fall into a fixed line pattern when its input is a long run of ones. A run detector prevents this. It counts consecutive ones at the scrambler input. After a run of the configured length, it inverts the next input bit before that bit enters the feedback. When scrambling is off, input bits pass to the output unchanged, with the same one-bit-time register delay. The scrambler state is frozen during this time, so re-enabling picks up from the history held before.

Top module: `ones_guard_scrambler`

## Requirements
- R1: A synchronous active-low reset clears the output bit, the 17-bit output history and the ones-run count to zero.
- R2: With scrambling on, each bit accepted on `bit_en` gives `dout` = b XOR y(n-14) XOR y(n-17). Here b is the (possibly inverted) input bit and y(n-k) is the scrambled bit produced k accepted bits earlier. `dout` is valid after the same rising edge that accepts the bit.
- R3: While `bit_en` is low, `dout`, the history and the run count do not change, whatever `din` does.
- R4: Once 64 consecutive input ones have been accepted, the next accepted input bit is inverted before scrambling.
- R5: The bit that receives the forced inversion is not counted. Counting restarts with the bit after it, so a continuous ones input is inverted on every 65th bit.
- R6: An accepted zero input clears the run count. A run broken by a zero must again reach 64 ones before any inversion.
- R7: With `scr_on` low, each accepted bit gives `dout` = `din`. The history and the run count are held.
- R8: When `scr_on` returns high, scrambling continues from the history and run count held before the bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable; one bit accepted per high cycle |
| scr_on | input | 1 | 1 = scramble, 0 = pass input straight through |
| din | input | 1 | Serial data bit from the character transmitter |
| dout | output | 1 | Line bit to the modulator, registered |

## Verification
The bench builds the block with its default parameters: taps at 14 and 17, a run length of 64 and the guard present. A run of 64 ones needs only 65 accepted bits, so a stream of about 140 ones reaches both the first forced inversion and the second one, 65 bits later. A run of 63 ones broken by a zero tests the boundary one bit short of the limit. Impulse and mixed patterns reach both feedback taps. Bypass phases placed in the middle of a scrambled stream show that the frozen history carries over.

// File: rtl/scr_pkg.sv
// Package: shared defaults for the ones-guard scrambler.
// Assumes: taps are given as delays in accepted bits, TAP_NEAR < TAP_FAR.
package scr_pkg;
    localparam int DEF_TAP_NEAR = 14;
    localparam int DEF_TAP_FAR  = 17;
    localparam int DEF_RUN_LEN  = 64;
endpackage

// File: rtl/scr_history.sv
// Module: output-history shift register and feedback XOR.
// Computes line bit = in_bit ^ y(n-TAP_NEAR) ^ y(n-TAP_FAR) combinationally and
// shifts that bit into the history on each step. Assumes TAP_NEAR < TAP_FAR.
module scr_history #(
    parameter int TAP_NEAR = 14,
    parameter int TAP_FAR  = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic in_bit,
    output logic out_bit
);
    localparam int DEPTH = TAP_FAR;

    logic [DEPTH-1:0] hist;   // hist[k-1] holds y(n-k)

    // Feedback: combine the new bit with the two delayed outputs.
    always_comb out_bit = in_bit ^ hist[TAP_NEAR-1] ^ hist[TAP_FAR-1];

    // History: shift in the produced bit on each accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (step)
            hist <= {hist[DEPTH-2:0], out_bit};
    end

    // History frozen when no step is taken.
    assert_hist_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(hist));
endmodule

// File: rtl/scr_run_guard.sv
// Module: consecutive-ones run detector.
// Counts accepted ones at the raw input. When RUN_LEN have been seen, flags the
// next accepted bit for inversion and restarts from zero; that bit is not counted.
module scr_run_guard #(
    parameter int RUN_LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic din,
    output logic force_inv
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run_cnt;

    // Inversion is due once the count has reached the run length.
    always_comb force_inv = (run_cnt == CW'(RUN_LEN));

    // Counter: clear on zero or forced bit, else count a one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (step) begin
            if (force_inv || !din)
                run_cnt <= '0;
            else
                run_cnt <= run_cnt + 1'b1;
        end
    end

    // Count never passes the run length.
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CW'(RUN_LEN));
    // Forced bit is not counted: count restarts.
    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step && force_inv |=> run_cnt == '0);
    // A zero clears the run.
    assert_zero_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step && !din |=> run_cnt == '0);
    // Count held without a step.
    assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(run_cnt));
endmodule

// File: rtl/ones_guard_scrambler.sv
// Module: top of the transmit scrambler with ones-run guard and bypass.
// One bit accepted per bit_en; dout registered on that edge. With scr_on low the
// bit passes through and all scrambler state is held. GUARD_EN selects whether
// the run detector is built.
module ones_guard_scrambler
    import scr_pkg::*;
#(
    parameter int TAP_NEAR = DEF_TAP_NEAR,
    parameter int TAP_FAR  = DEF_TAP_FAR,
    parameter int RUN_LEN  = DEF_RUN_LEN,
    parameter bit GUARD_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic scr_on,
    input  logic din,
    output logic dout
);
    logic step;
    logic force_inv;
    logic guarded_bit;
    logic scr_bit;

    // Scrambler state advances only on accepted bits while scrambling.
    always_comb step = bit_en && scr_on;

    generate
        if (GUARD_EN) begin : g_guard
            scr_run_guard #(.RUN_LEN(RUN_LEN)) u_guard (
                .clk(clk), .rst_n(rst_n), .step(step),
                .din(din), .force_inv(force_inv));
        end else begin : g_noguard
            assign force_inv = 1'b0;
        end
    endgenerate

    // Apply the forced inversion ahead of the feedback.
    always_comb guarded_bit = din ^ force_inv;

    scr_history #(.TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_hist (
        .clk(clk), .rst_n(rst_n), .step(step),
        .in_bit(guarded_bit), .out_bit(scr_bit));

    // Output register: scrambled or pass-through bit on each accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= 1'b0;
        else if (bit_en)
            dout <= scr_on ? scr_bit : din;
    end

    // Bypass passes the input unchanged.
    assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && !scr_on |=> dout == $past(din));
    // Output holds between accepted bits.
    assert_dout_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(dout));
endmodule

// File: tb/ones_guard_scrambler_tb.sv
`timescale 1ns/1ps
module ones_guard_scrambler_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic scr_on = 1'b1;
    logic din = 1'b0;
    logic dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state, built from the requirements
    logic mh [1:17];
    int   mcnt;
    int   nforced;

    always #2.5 clk = ~clk;

    ones_guard_scrambler u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .scr_on(scr_on), .din(din), .dout(dout));

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int k = 1; k <= 17; k++) mh[k] = 1'b0;
        mcnt = 0;
        nforced = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // Send one bit and compare dout with the reference after the capturing edge.
    task automatic send_bit(input logic b, input string req);
        logic exp;
        logic f;
        logic ib;
        @(negedge clk);
        din = b; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        if (scr_on) begin
            f = (mcnt == 64);
            ib = b ^ f;
            exp = ib ^ mh[14] ^ mh[17];
            if (f) begin mcnt = 0; nforced++; end
            else if (b) mcnt++;
            else mcnt = 0;
            for (int k = 17; k > 1; k--) mh[k] = mh[k-1];
            mh[1] = exp;
        end else begin
            exp = b;
        end
        chk(req, dout, exp);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", dout, 1'b0);
        for (int i = 0; i < 20; i++) send_bit(1'b0, "R1");
    endtask

    task automatic t_impulse();
        do_reset();
        send_bit(1'b1, "R2");
        for (int i = 0; i < 50; i++) send_bit(1'b0, "R2");
        for (int i = 0; i < 60; i++) send_bit(logic'((i * 7 + 3) % 5 < 2), "R2");
    endtask

    task automatic t_all_ones();
        do_reset();
        for (int i = 0; i < 140; i++)
            send_bit(1'b1, (i == 64) ? "R4" : "R5");
        checks++;
        if (nforced != 2) begin
            errors++;
            $display("FAIL R5 forced count got %0d expected 2", nforced);
        end
    endtask

    task automatic t_broken_run();
        do_reset();
        for (int i = 0; i < 63; i++) send_bit(1'b1, "R6");
        send_bit(1'b0, "R6");
        for (int i = 0; i < 66; i++) send_bit(1'b1, "R6");
    endtask

    task automatic t_enable_low();
        logic held;
        do_reset();
        for (int i = 0; i < 20; i++) send_bit(logic'(i % 3 == 0), "R3");
        held = dout;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            din = logic'(i % 2);
            chk("R3", dout, held);
        end
        for (int i = 0; i < 30; i++) send_bit(logic'(i % 4 == 1), "R3");
    endtask

    task automatic t_bypass();
        do_reset();
        for (int i = 0; i < 70; i++) send_bit(logic'(i != 40), "R8");
        scr_on = 1'b0;
        for (int i = 0; i < 20; i++) send_bit(logic'(i % 3 != 0), "R7");
        scr_on = 1'b1;
        for (int i = 0; i < 40; i++) send_bit(logic'(i % 5 != 2), "R8");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        t_reset();
        t_impulse();
        t_all_ones();
        t_broken_run();
        t_enable_low();
        t_bypass();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule